// File: doc/BRIEF.md
# CAN Receive Fragment Reassembly Writer

This block sits behind the receive path of a CAN controller and serves one message object. Each accepted frame reaches it as a strobe with its IDE and RTR flags, two semaphore bits, a 4-bit data length code, up to eight data bytes and an end-of-message flag. The end-of-message flag is decoded upstream from the fragmentation byte. The block writes the frame into a circular byte buffer in local RAM through a byte-wide write port and generates every write address itself. A buffer base and a buffer size set where the buffer lies.

When fragmentation is enabled and the protocol select is non-zero, the block runs in transport mode. It drops the fragmentation control byte of each frame and appends the remaining payload behind the bytes already stored. When the message ends, it writes the total byte count into offset 0. When the protocol select is zero, it runs in raw mode and stores every frame as an info byte followed by its data, with no count. Both modes wrap at the top of the buffer and raise a warning level before the wrap. Raw mode also flags a nearly full buffer.

While the block is writing, it holds off new frames with a ready/valid handshake. It writes one byte per clock and pulses a completion output once the last byte of a message or frame has been written.

Top module: `can_frag_writer`

## Requirements
- R1: A synchronous reset sets the write pointer to offset 1 in transport mode and to offset 0 in raw mode. It clears the byte count, `warn_irq`, `buf_full` and `msg_done`, leaves `wr_en` low and `frm_ready` high. Configuration is held steady between resets.
- R2: In transport mode (`cfg_frag`=1, `cfg_proto`≠00), data byte 1 (`frm_data[7:0]`) is not stored. Data bytes 2 through DLC (byte n at `frm_data[8n-1 -: 8]`) are written at consecutive offsets, and each later frame continues directly after the last byte stored.
- R3: In transport mode, a frame with `frm_eom`=1 is followed, after its data writes, by one write of the message's stored byte count (modulo 256) to offset 0. The next message then starts at offset 1 with a count of zero.
- R4: In raw mode (`cfg_frag`=1, `cfg_proto`=00), each frame is written as an info byte followed by data bytes 1 through DLC, and no count is written. The info byte holds IDE in bit 7, RTR in bit 6, the semaphore bits in bits 5:4 and the DLC in bits 3:0.
- R5: In raw mode, `buf_full` is updated after each frame's last write. It is 1 exactly when the buffer size minus the next write offset is less than 9.
- R6: The write address is always `cfg_base` plus the offset. When the offset would reach `cfg_size`, it wraps to 0 in transport mode and to 1 in raw mode.
- R7: After each write, `warn_irq` is 1 exactly when the buffer size minus the next write offset is less than `WARN_THR` (default 8).
- R8: `msg_done` pulses for one cycle, in the cycle after the last write of a message: the count write in transport mode, or the frame's final byte in raw mode.
- R9: `frm_ready` is high only while no write sequence is running. A frame is taken when `frm_valid` and `frm_ready` are both high, its first write follows in the next cycle, and one byte is written per cycle.
- R10: A DLC above 8 stores 8 data bytes. The info byte keeps the DLC value as received.
- R11: With `cfg_frag`=0, frames are accepted and discarded: no write and no `msg_done`.
- R12: In transport mode, a frame with DLC below 2 writes no data. If it carries `frm_eom`, the count is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Block idle and able to take a frame |
| frm_ide | input | 1 | Extended identifier flag of the frame |
| frm_rtr | input | 1 | Remote request flag of the frame |
| frm_sem | input | 2 | Semaphore bits |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 8*NB | Data bytes, byte 1 in bits 7:0 |
| frm_eom | input | 1 | Frame ends a fragmented message |
| cfg_frag | input | 1 | Fragment handling enable |
| cfg_proto | input | 2 | Protocol select, 00 selects raw mode |
| cfg_base | input | ADDR_W | Buffer base address |
| cfg_size | input | OFS_W | Buffer size in bytes |
| wr_en | output | 1 | RAM byte write strobe |
| wr_addr | output | ADDR_W | RAM write address |
| wr_data | output | 8 | RAM write byte |
| warn_irq | output | 1 | Space below the top under threshold |
| buf_full | output | 1 | Raw-mode buffer nearly full |
| msg_done | output | 1 | Message or frame fully written |

## Verification
A wrong internal pointer shows at `wr_addr` on the very next write strobe. The bench mirrors every write into a shadow RAM and compares the whole buffer against a model of the offsets, so a slip in append or wrap logic appears as a misplaced byte once the frame finishes. A wrong byte count stays hidden until the end-of-message write at offset 0. That is why multi-frame messages, header-only frames and a message that wraps across the count slot are all checked there. The full and warning levels are registered from the next pointer, so an error in their thresholds is visible the cycle after a frame's last write. The 9-byte and 8-byte boundaries are both hit exactly.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

    localparam int BYTE_W       = 8;
    localparam int RAW_FULL_MIN = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_COUNT
    } wr_state_e;

    function automatic logic [7:0] pack_info(input logic ide, input logic rtr,
                                             input logic [1:0] sem, input logic [3:0] dlc);
        return {ide, rtr, sem, dlc};
    endfunction

endpackage

// File: rtl/cfw_ptr_step.sv
module cfw_ptr_step #(
    parameter int OFS_W = 8
) (
    input  logic [OFS_W-1:0] ptr_i,
    input  logic [OFS_W-1:0] size_i,
    input  logic             wrap_one_i,
    output logic [OFS_W-1:0] nxt_o
);
    logic [OFS_W:0] inc;

    always_comb begin
        inc = {1'b0, ptr_i} + (OFS_W+1)'(1);
        if (inc >= {1'b0, size_i}) begin
            nxt_o = wrap_one_i ? OFS_W'(1) : '0;
        end else begin
            nxt_o = inc[OFS_W-1:0];
        end
    end
endmodule

// File: rtl/cfw_byte_pick.sv
module cfw_byte_pick #(
    parameter int NB = 8
) (
    input  logic [7:0]      info_i,
    input  logic [8*NB-1:0] data_i,
    input  logic [3:0]      k_i,
    output logic [7:0]      byte_o
);
    logic [7:0] lane [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane[g] = data_i[g*8 +: 8];
    end

    always_comb begin
        byte_o = info_i;
        for (int i = 0; i < NB; i++) begin
            if (int'(k_i) == i + 1) begin
                byte_o = lane[i];
            end
        end
    end
endmodule

// File: rtl/cfw_ctrl.sv
module cfw_ctrl
    import cfw_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int OFS_W    = 8,
    parameter int NB       = 8,
    parameter int WARN_THR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    output logic              frm_ready,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    input  logic [1:0]        frm_sem,
    input  logic [3:0]        frm_dlc,
    input  logic [8*NB-1:0]   frm_data,
    input  logic              frm_eom,
    input  logic              cfg_frag,
    input  logic [1:0]        cfg_proto,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [OFS_W-1:0]  cfg_size,
    input  logic [OFS_W-1:0]  step_nxt,
    input  logic [7:0]        pick_byte,
    output logic [OFS_W-1:0]  cur_ptr,
    output logic [3:0]        cur_k,
    output logic [7:0]        cur_info,
    output logic [8*NB-1:0]   cur_data,
    output logic              cur_raw,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              warn_irq,
    output logic              buf_full,
    output logic              msg_done
);
    localparam logic [OFS_W:0] WARN_LIM = (OFS_W+1)'(WARN_THR);
    localparam logic [OFS_W:0] FULL_LIM = (OFS_W+1)'(RAW_FULL_MIN);
    localparam logic [3:0]     NB_DLC   = 4'(NB);

    typedef struct packed {
        wr_state_e        st;
        logic [OFS_W-1:0] ptr;
        logic [7:0]       cnt;
        logic [3:0]       k;
        logic [3:0]       kend;
        logic             last;
        logic             raw;
        logic [7:0]       info;
        logic [8*NB-1:0]  data;
        logic             done;
        logic             full;
        logic             warn;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic       raw_cfg;
    logic [3:0] dlc_c;

    function automatic logic space_below(input logic [OFS_W-1:0] p,
                                         input logic [OFS_W-1:0] sz,
                                         input logic [OFS_W:0]   lim);
        logic [OFS_W:0] sp;
        if (p >= sz) begin
            return 1'b1;
        end
        sp = {1'b0, sz} - {1'b0, p};
        return sp < lim;
    endfunction

    assign raw_cfg = cfg_frag && (cfg_proto == 2'b00);
    assign dlc_c   = (frm_dlc > NB_DLC) ? NB_DLC : frm_dlc;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        frm_ready  = (ctl_q.st == ST_IDLE);
        wr_en      = 1'b0;
        wr_addr    = cfg_base + ADDR_W'(ctl_q.ptr);
        wr_data    = pick_byte;

        case (ctl_q.st)
            ST_IDLE: begin
                if (frm_valid && cfg_frag) begin
                    ctl_d.info = pack_info(frm_ide, frm_rtr, frm_sem, frm_dlc);
                    ctl_d.data = frm_data;
                    ctl_d.last = frm_eom;
                    ctl_d.raw  = raw_cfg;
                    if (raw_cfg) begin
                        ctl_d.k    = 4'd0;
                        ctl_d.kend = dlc_c;
                        ctl_d.st   = ST_DATA;
                    end else if (dlc_c >= 4'd2) begin
                        ctl_d.k    = 4'd2;
                        ctl_d.kend = dlc_c;
                        ctl_d.st   = ST_DATA;
                    end else if (frm_eom) begin
                        ctl_d.st   = ST_COUNT;
                    end
                end
            end
            ST_DATA: begin
                wr_en     = 1'b1;
                ctl_d.ptr = step_nxt;
                if (!ctl_q.raw) begin
                    ctl_d.cnt = ctl_q.cnt + 8'd1;
                end
                if (ctl_q.k == ctl_q.kend) begin
                    if (ctl_q.raw) begin
                        ctl_d.done = 1'b1;
                        ctl_d.full = space_below(step_nxt, cfg_size, FULL_LIM);
                        ctl_d.st   = ST_IDLE;
                    end else begin
                        ctl_d.st   = ctl_q.last ? ST_COUNT : ST_IDLE;
                    end
                end else begin
                    ctl_d.k = ctl_q.k + 4'd1;
                end
            end
            ST_COUNT: begin
                wr_en      = 1'b1;
                wr_addr    = cfg_base;
                wr_data    = ctl_q.cnt;
                ctl_d.done = 1'b1;
                ctl_d.ptr  = OFS_W'(1);
                ctl_d.cnt  = 8'd0;
                ctl_d.st   = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        ctl_d.warn = space_below(ctl_d.ptr, cfg_size, WARN_LIM);

        if (rst) begin
            ctl_d     = '0;
            ctl_d.st  = ST_IDLE;
            ctl_d.ptr = raw_cfg ? '0 : OFS_W'(1);
            ctl_d.raw = raw_cfg;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign cur_ptr  = ctl_q.ptr;
    assign cur_k    = ctl_q.k;
    assign cur_info = ctl_q.info;
    assign cur_data = ctl_q.data;
    assign cur_raw  = ctl_q.raw;
    assign warn_irq = ctl_q.warn;
    assign buf_full = ctl_q.full;
    assign msg_done = ctl_q.done;
endmodule

// File: rtl/can_frag_writer.sv
module can_frag_writer #(
    parameter int ADDR_W   = 8,
    parameter int OFS_W    = 8,
    parameter int NB       = 8,
    parameter int WARN_THR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    output logic              frm_ready,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    input  logic [1:0]        frm_sem,
    input  logic [3:0]        frm_dlc,
    input  logic [8*NB-1:0]   frm_data,
    input  logic              frm_eom,
    input  logic              cfg_frag,
    input  logic [1:0]        cfg_proto,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [OFS_W-1:0]  cfg_size,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              warn_irq,
    output logic              buf_full,
    output logic              msg_done
);
    logic [OFS_W-1:0] ptr_w;
    logic [OFS_W-1:0] nxt_w;
    logic [3:0]       k_w;
    logic [7:0]       info_w;
    logic [7:0]       byte_w;
    logic [8*NB-1:0]  data_w;
    logic             raw_w;

    cfw_ptr_step #(.OFS_W(OFS_W)) i_step (
        .ptr_i      (ptr_w),
        .size_i     (cfg_size),
        .wrap_one_i (raw_w),
        .nxt_o      (nxt_w)
    );

    cfw_byte_pick #(.NB(NB)) i_pick (
        .info_i (info_w),
        .data_i (data_w),
        .k_i    (k_w),
        .byte_o (byte_w)
    );

    cfw_ctrl #(
        .ADDR_W   (ADDR_W),
        .OFS_W    (OFS_W),
        .NB       (NB),
        .WARN_THR (WARN_THR)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .frm_valid (frm_valid),
        .frm_ready (frm_ready),
        .frm_ide   (frm_ide),
        .frm_rtr   (frm_rtr),
        .frm_sem   (frm_sem),
        .frm_dlc   (frm_dlc),
        .frm_data  (frm_data),
        .frm_eom   (frm_eom),
        .cfg_frag  (cfg_frag),
        .cfg_proto (cfg_proto),
        .cfg_base  (cfg_base),
        .cfg_size  (cfg_size),
        .step_nxt  (nxt_w),
        .pick_byte (byte_w),
        .cur_ptr   (ptr_w),
        .cur_k     (k_w),
        .cur_info  (info_w),
        .cur_data  (data_w),
        .cur_raw   (raw_w),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .warn_irq  (warn_irq),
        .buf_full  (buf_full),
        .msg_done  (msg_done)
    );
endmodule

// File: rtl/cfw_chk.sv
module cfw_chk #(
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_ready,
    input logic              cfg_frag,
    input logic [1:0]        cfg_proto,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [OFS_W-1:0]  cfg_size,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              buf_full,
    input logic              msg_done
);
    // R9
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !frm_ready);

    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        msg_done |-> $past(wr_en));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        msg_done |=> !msg_done);

    // R6
    addr_in_buffer_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ADDR_W'(wr_addr - cfg_base) < ADDR_W'(cfg_size)));

    // R5
    full_raw_only_chk: assert property (@(posedge clk) disable iff (rst)
        buf_full |-> (cfg_frag && cfg_proto == 2'b00));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!wr_en && frm_ready && !buf_full && !msg_done));
endmodule

bind can_frag_writer cfw_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_ready (frm_ready),
    .cfg_frag  (cfg_frag),
    .cfg_proto (cfg_proto),
    .cfg_base  (cfg_base),
    .cfg_size  (cfg_size),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .buf_full  (buf_full),
    .msg_done  (msg_done)
);

// File: tb/test_can_frag_writer.sv
module test_can_frag_writer;
    localparam int         NB   = 8;
    localparam logic [7:0] BASE = 8'h40;
    localparam int         SIZE = 32;
    localparam int         WARN = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            frm_valid = 1'b0;
    logic            frm_ready;
    logic            frm_ide = 1'b0;
    logic            frm_rtr = 1'b0;
    logic [1:0]      frm_sem = 2'b00;
    logic [3:0]      frm_dlc = 4'd0;
    logic [8*NB-1:0] frm_data = '0;
    logic            frm_eom = 1'b0;
    logic            cfg_frag = 1'b1;
    logic [1:0]      cfg_proto = 2'b01;
    logic [7:0]      cfg_base = BASE;
    logic [7:0]      cfg_size = 8'(SIZE);
    logic            wr_en;
    logic [7:0]      wr_addr;
    logic [7:0]      wr_data;
    logic            warn_irq;
    logic            buf_full;
    logic            msg_done;

    int n_chk = 0;
    int n_err = 0;
    int wr_cnt = 0;
    int done_cnt = 0;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];
    int  e_ptr;
    int  e_cnt;
    bit  e_raw;
    bit  e_full;

    always #4 clk = ~clk;

    can_frag_writer i_can_frag_writer (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_sem(frm_sem), .frm_dlc(frm_dlc),
        .frm_data(frm_data), .frm_eom(frm_eom), .cfg_frag(cfg_frag),
        .cfg_proto(cfg_proto), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .warn_irq(warn_irq), .buf_full(buf_full), .msg_done(msg_done)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (msg_done) done_cnt <= done_cnt + 1;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_buf(input string req);
        int bad = -1;
        for (int i = 0; i < SIZE; i++) begin
            if (bad < 0 && mem[BASE + 8'(i)] !== exp_mem[BASE + 8'(i)]) bad = i;
        end
        n_chk++;
        if (bad >= 0) begin
            n_err++;
            $display("FAIL %s buffer offset %0d: got %0h expected %0h", req, bad,
                     mem[BASE + 8'(bad)], exp_mem[BASE + 8'(bad)]);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic put(input logic [7:0] b);
        exp_mem[BASE + 8'(e_ptr)] = b;
        e_ptr++;
        if (e_ptr >= SIZE) e_ptr = e_raw ? 1 : 0;
    endtask

    task automatic do_reset(input logic frag, input logic [1:0] proto);
        @(negedge clk);
        cfg_frag = frag;
        cfg_proto = proto;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        e_raw = frag && (proto == 2'b00);
        e_ptr = e_raw ? 0 : 1;
        e_cnt = 0;
        e_full = 0;
        // R1: reset state
        check_eq("R1", "frm_ready after reset", int'(frm_ready), 1);
        check_eq("R1", "wr_en after reset", int'(wr_en), 0);
        check_eq("R1", "warn_irq after reset", int'(warn_irq), 0);
        check_eq("R1", "buf_full after reset", int'(buf_full), 0);
        check_eq("R1", "msg_done after reset", int'(msg_done), 0);
    endtask

    task automatic send(input logic ide, input logic rtr, input logic [1:0] sem,
                        input logic [3:0] dlc, input logic eom, input logic [7:0] seed);
        int nb = (dlc > 4'd8) ? 8 : int'(dlc);
        int w0 = wr_cnt;
        int d0 = done_cnt;
        int exp_w;
        int exp_d;
        int guard = 0;
        bit busy;
        string rq;
        logic [8*NB-1:0] dat;
        for (int n = 1; n <= NB; n++) dat[(n-1)*8 +: 8] = seed + 8'(n);
        rq = !cfg_frag ? "R11" : e_raw ? ((dlc > 4'd8) ? "R10" : "R4") : ((nb < 2) ? "R12" : "R2");
        frm_ide = ide; frm_rtr = rtr; frm_sem = sem; frm_dlc = dlc;
        frm_data = dat; frm_eom = eom; frm_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frm_valid = 1'b0;
        busy = cfg_frag && (e_raw || nb >= 2 || eom);
        // R9: handshake drops ready and the first write follows at once
        check_eq("R9", "frm_ready after accept", int'(frm_ready), busy ? 0 : 1);
        check_eq("R9", "wr_en after accept", int'(wr_en), busy ? 1 : 0);
        while (!frm_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        exp_w = 0;
        exp_d = 0;
        if (cfg_frag) begin
            if (e_raw) begin
                put({ide, rtr, sem, dlc});
                for (int n = 1; n <= nb; n++) put(dat[(n-1)*8 +: 8]);
                e_full = (SIZE - e_ptr) < 9;
                exp_w = nb + 1;
                exp_d = 1;
            end else begin
                for (int n = 2; n <= nb; n++) begin
                    put(dat[(n-1)*8 +: 8]);
                    e_cnt++;
                    exp_w++;
                end
                if (eom) begin
                    exp_mem[BASE] = 8'(e_cnt);
                    e_ptr = 1;
                    e_cnt = 0;
                    exp_w++;
                    exp_d = 1;
                end
            end
        end
        check_eq(rq, "writes for frame", wr_cnt - w0, exp_w);
        // R8: completion pulses
        check_eq("R8", "msg_done pulses", done_cnt - d0, exp_d);
        // R7: warning level
        check_eq("R7", "warn_irq", int'(warn_irq), ((SIZE - e_ptr) < WARN) ? 1 : 0);
        // R5: full level
        check_eq("R5", "buf_full", int'(buf_full), int'(e_full));
    endtask

    task automatic t_xport_message();
        do_reset(1'b1, 2'b01);
        send(1'b1, 1'b0, 2'b00, 4'd8, 1'b0, 8'h10);
        send(1'b1, 1'b0, 2'b00, 4'd5, 1'b0, 8'h20);
        send(1'b1, 1'b0, 2'b00, 4'd3, 1'b1, 8'h30);
        cmp_buf("R2");
        check_eq("R3", "count at offset 0", int'(mem[BASE]), 13);
        check_eq("R2", "first payload is byte 2", int'(mem[BASE + 8'd1]), 8'h12);
    endtask

    task automatic t_xport_short();
        send(1'b0, 1'b0, 2'b01, 4'd1, 1'b0, 8'h40);
        send(1'b0, 1'b0, 2'b01, 4'd0, 1'b1, 8'h50);
        cmp_buf("R12");
        check_eq("R12", "count of empty message", int'(mem[BASE]), 0);
    endtask

    task automatic t_xport_wrap();
        for (int f = 0; f < 4; f++) send(1'b1, 1'b1, 2'b11, 4'd8, 1'b0, 8'(8'h60 + 8'(f * 16)));
        send(1'b1, 1'b1, 2'b11, 4'd8, 1'b1, 8'hA0);
        cmp_buf("R6");
        check_eq("R3", "count after wrap", int'(mem[BASE]), 35);
        check_eq("R6", "byte wrapped to offset 3", int'(mem[BASE + 8'd3]), 8'hA8);
    endtask

    task automatic t_raw();
        do_reset(1'b1, 2'b00);
        send(1'b1, 1'b0, 2'b10, 4'd3, 1'b0, 8'h00);
        check_eq("R4", "info byte at offset 0", int'(mem[BASE]), 8'hA3);
        send(1'b0, 1'b1, 2'b01, 4'd0, 1'b0, 8'h00);
        check_eq("R4", "info byte of empty frame", int'(mem[BASE + 8'd4]), 8'h50);
        send(1'b0, 1'b0, 2'b00, 4'd8, 1'b0, 8'h10);
        send(1'b0, 1'b0, 2'b00, 4'd8, 1'b1, 8'h20);
        check_eq("R5", "full clear at 9 left", int'(buf_full), 0);
        send(1'b0, 1'b0, 2'b00, 4'd0, 1'b0, 8'h00);
        check_eq("R5", "full set at 8 left", int'(buf_full), 1);
        send(1'b1, 1'b1, 2'b11, 4'd8, 1'b0, 8'h70);
        cmp_buf("R4");
        check_eq("R6", "raw wrap keeps offset 0", int'(mem[BASE]), 8'hA3);
        check_eq("R6", "raw wrap lands at offset 1", int'(mem[BASE + 8'd1]), 8'h78);
    endtask

    task automatic t_dlc_clamp();
        send(1'b0, 1'b0, 2'b00, 4'd12, 1'b0, 8'h80);
        cmp_buf("R10");
        check_eq("R10", "info keeps DLC 12", int'(mem[BASE + 8'd2]), 8'h0C);
    endtask

    task automatic t_frag_off();
        do_reset(1'b0, 2'b01);
        send(1'b1, 1'b0, 2'b00, 4'd8, 1'b1, 8'h90);
        send(1'b0, 1'b0, 2'b00, 4'd4, 1'b0, 8'hB0);
        cmp_buf("R11");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got run still busy expected finished");
        report();
        $finish;
    end

    initial begin
        t_xport_message();
        t_xport_short();
        t_xport_wrap();
        t_raw();
        t_dlc_clamp();
        t_frag_off();
        report();
        $finish;
    end
endmodule